// File: doc/BRIEF.md
# Ternary-Table Packet Parser

This block pulls the header fields out of a packet using a parse state machine that lives in a loadable ternary match table rather than in fixed logic. Packet bytes arrive as 32-bit words and are held in a small header window. Parsing starts in state 0 with the cursor at byte 0 and does one lookup per clock cycle. Each lookup forms a 40-bit key from the current state and the four bytes at the cursor, and compares it with every valid table entry under that entry's care mask. The lowest-numbered entry that matches decides four things: the next state, how far the cursor moves, how many bytes are copied and where in the packet header vector they are placed.

When an entry names the reserved final state, the parser presents the filled header vector for one cycle. The vector carries a fixed instance tag, so several parsers can feed one shared match-action pipeline. Parsing fails, and the partial vector is discarded, in three cases: no entry matches, a move would pass the end of the packet, or the walk runs too many steps. Entries are written through a single write port, and a write only takes effect while the parser is idle. New header types can therefore be added at run time.

Top module: `tcam_parser`

## Requirements
- R1: After reset, in_ready is 1, phv_valid and parse_error are 0, phv_data is all zero, and every table entry is disabled, so a packet sent before any entry is written fails on its first lookup.
- R2: Each accepted word (in_valid with in_ready high) carries packet bytes in order, first byte in in_data[31:24]. A word with in_last set holds in_nbytes bytes (1 to 3), and any other in_nbytes value counts as 4. in_ready is low from the cycle after the last word until a result is produced, and it is high again in the cycle the result appears.
- R3: The lookup key is {state[7:0], b0, b1, b2, b3}, where b0 is the byte at the cursor and sits in key[31:24]. A key bit is compared only where the entry's care bit is 1. Bytes at or beyond the packet length, or beyond the BUF_BYTES header window, read as zero.
- R4: When several enabled entries match, the entry with the lowest index is used.
- R5: A matching entry copies xlen bytes, starting at the cursor, into header vector bytes xoff, xoff+1 and so on. Vector byte j is phv_data[8*j+7:8*j]. Bytes that would land at or beyond PHV_BYTES are dropped, and bytes not written by any step stay zero.
- R6: On a non-final match, the cursor moves forward by the entry's advance and the state becomes its next state. An advance written above 16 is stored as 16.
- R7: A match whose next state is 8'hFF ends parsing. Its extraction is included in the vector, and phv_valid is high for exactly one cycle: the s-th lookup's result is visible in the s-th cycle after the edge that accepts the last word.
- R8: A lookup with no matching entry raises parse_error for one cycle, with the same timing as R7, and phv_data reads zero in that cycle.
- R9: A matching entry whose advance would put the cursor beyond the packet length raises parse_error and clears the vector. This holds for a final entry as well.
- R10: If MAX_STEPS lookups complete without reaching the final state, the last of them raises parse_error and clears the vector.
- R11: A table write (tbl_we) takes effect only when the parser is idle, meaning no packet is being received or parsed. Writes at any other time are ignored.
- R12: phv_tag equals the INST_ID parameter whenever phv_valid or parse_error is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | IDX_W | Entry index to write |
| tbl_en | input | 1 | Entry enable |
| tbl_val | input | 40 | Key value to compare |
| tbl_care | input | 40 | Care mask, 1 = compare bit |
| tbl_next | input | 8 | Next state, 8'hFF = final |
| tbl_adv | input | 5 | Cursor advance in bytes (clamped to 16) |
| tbl_xlen | input | 4 | Bytes to copy |
| tbl_xoff | input | OFF_W | Destination byte in header vector |
| in_valid | input | 1 | Word valid |
| in_ready | output | 1 | Parser can take a word |
| in_data | input | 32 | Packet word, first byte in the top bits |
| in_last | input | 1 | Final word of packet |
| in_nbytes | input | 3 | Valid bytes in the final word |
| phv_valid | output | 1 | Header vector complete (one cycle) |
| phv_data | output | PHV_BYTES*8 | Packet header vector |
| phv_tag | output | TAG_W | Instance tag |
| parse_error | output | 1 | Parse failed (one cycle) |

## Verification
Lookups run one per cycle, starting at the edge after the last word is accepted. The result of lookup s therefore appears in cycle s after that edge. The bench counts falling edges from that point and compares the count with the step number predicted by its reference walk of the table, so a result that comes early or late is flagged as well as a wrong one. Vector contents, the error flag and the tag are sampled in the same cycle. One cycle later the bench checks that the pulse has dropped. For writes during a parse, the bench sends a packet right afterwards whose result depends on whether the write took effect.

// File: rtl/tcam_parser.sv
`timescale 1ns/1ps
module tcam_parser #(
  parameter int ENTRIES   = 16,
  parameter int BUF_BYTES = 64,
  parameter int PHV_BYTES = 32,
  parameter int MAX_STEPS = 16,
  parameter int TAG_W     = 4,
  parameter int INST_ID   = 0,
  localparam int KEY_W    = 40,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int OFF_W    = $clog2(PHV_BYTES),
  localparam int PHV_W    = PHV_BYTES * 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic             tbl_en,
  input  logic [KEY_W-1:0] tbl_val,
  input  logic [KEY_W-1:0] tbl_care,
  input  logic [7:0]       tbl_next,
  input  logic [4:0]       tbl_adv,
  input  logic [3:0]       tbl_xlen,
  input  logic [OFF_W-1:0] tbl_xoff,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [31:0]      in_data,
  input  logic             in_last,
  input  logic [2:0]       in_nbytes,
  output logic             phv_valid,
  output logic [PHV_W-1:0] phv_data,
  output logic [TAG_W-1:0] phv_tag,
  output logic             parse_error
);
  localparam int LEN_W  = 16;
  localparam int BUF_AW = $clog2(BUF_BYTES);
  localparam int STEP_W = $clog2(MAX_STEPS + 1);
  localparam logic [LEN_W:0] BUF_N = (LEN_W+1)'(BUF_BYTES);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(MAX_STEPS - 1);

  typedef enum logic [1:0] {S_IDLE, S_RX, S_PARSE} fsm_t;

  fsm_t               fsm_q;
  logic [LEN_W-1:0]   len_q, cur_q;
  logic [7:0]         pst_q;
  logic [STEP_W-1:0]  step_q;
  logic [PHV_W-1:0]   phv_q, phv_ext;
  logic               done_q, err_q;
  logic [7:0]         buf_q [BUF_BYTES];

  logic [ENTRIES-1:0] ent_en;
  logic [KEY_W-1:0]   ent_val  [ENTRIES];
  logic [KEY_W-1:0]   ent_care [ENTRIES];
  logic [7:0]         ent_next [ENTRIES];
  logic [4:0]         ent_adv  [ENTRIES];
  logic [3:0]         ent_xlen [ENTRIES];
  logic [OFF_W-1:0]   ent_xoff [ENTRIES];

  logic               tbl_ok, take;
  logic [LEN_W:0]     wr_base;
  logic [2:0]         word_n;
  logic [31:0]        la;
  logic [KEY_W-1:0]   key;
  logic               hit;
  logic [IDX_W-1:0]   hit_i;
  logic [LEN_W:0]     adv_end;
  logic               overrun;

  assign in_ready    = (fsm_q != S_PARSE);
  assign phv_valid   = done_q;
  assign parse_error = err_q;
  assign phv_data    = phv_q;
  assign phv_tag     = TAG_W'(INST_ID);

  assign tbl_ok  = (fsm_q == S_IDLE) && tbl_we;
  assign take    = in_ready && in_valid;
  assign wr_base = (fsm_q == S_IDLE) ? '0 : {1'b0, len_q};
  assign word_n  = (in_last && in_nbytes != 3'd0 && in_nbytes < 3'd4) ? in_nbytes : 3'd4;

  function automatic logic [7:0] rdb(input logic [LEN_W:0] a);
    rdb = (a < {1'b0, len_q} && a < BUF_N) ? buf_q[a[BUF_AW-1:0]] : 8'h00;
  endfunction

  always_comb begin
    for (int k = 0; k < 4; k++)
      la[8*(3-k) +: 8] = rdb({1'b0, cur_q} + (LEN_W+1)'(k));
  end

  assign key = {pst_q, la};

  always_comb begin
    hit   = 1'b0;
    hit_i = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (ent_en[i] && (((key ^ ent_val[i]) & ent_care[i]) == '0)) begin
        hit   = 1'b1;
        hit_i = IDX_W'(i);
      end
  end

  assign adv_end = {1'b0, cur_q} + (LEN_W+1)'(ent_adv[hit_i]);
  assign overrun = adv_end > {1'b0, len_q};

  always_comb begin
    phv_ext = phv_q;
    for (int t = 0; t < 16; t++)
      if ((t < int'(ent_xlen[hit_i])) && (int'(ent_xoff[hit_i]) + t < PHV_BYTES))
        phv_ext[8*(int'(ent_xoff[hit_i]) + t) +: 8] = rdb({1'b0, cur_q} + (LEN_W+1)'(t));
  end

  always_ff @(posedge clk) begin
    if (tbl_ok) begin
      ent_val[tbl_addr]  <= tbl_val;
      ent_care[tbl_addr] <= tbl_care;
      ent_next[tbl_addr] <= tbl_next;
      ent_adv[tbl_addr]  <= (tbl_adv > 5'd16) ? 5'd16 : tbl_adv;
      ent_xlen[tbl_addr] <= tbl_xlen;
      ent_xoff[tbl_addr] <= tbl_xoff;
    end
  end

  always_ff @(posedge clk) begin
    if (take)
      for (int k = 0; k < 4; k++)
        if (wr_base + (LEN_W+1)'(k) < BUF_N)
          buf_q[BUF_AW'(wr_base + (LEN_W+1)'(k))] <= in_data[8*(3-k) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= S_IDLE;
      len_q  <= '0;
      cur_q  <= '0;
      pst_q  <= '0;
      step_q <= '0;
      phv_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ent_en <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (tbl_ok) ent_en[tbl_addr] <= tbl_en;
      case (fsm_q)
        S_IDLE: begin
          cur_q  <= '0;
          pst_q  <= '0;
          step_q <= '0;
          if (in_valid) begin
            phv_q <= '0;
            len_q <= LEN_W'(word_n);
            fsm_q <= in_last ? S_PARSE : S_RX;
          end
        end
        S_RX: begin
          if (in_valid) begin
            len_q <= len_q + LEN_W'(word_n);
            if (in_last) fsm_q <= S_PARSE;
          end
        end
        default: begin
          if (!hit || overrun) begin
            err_q <= 1'b1;
            phv_q <= '0;
            fsm_q <= S_IDLE;
          end else if (ent_next[hit_i] == 8'hFF) begin
            done_q <= 1'b1;
            phv_q  <= phv_ext;
            fsm_q  <= S_IDLE;
          end else if (step_q == LAST_STEP) begin
            err_q <= 1'b1;
            phv_q <= '0;
            fsm_q <= S_IDLE;
          end else begin
            phv_q  <= phv_ext;
            cur_q  <= adv_end[LEN_W-1:0];
            pst_q  <= ent_next[hit_i];
            step_q <= step_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tcam_parser_chk.sv
`timescale 1ns/1ps
module tcam_parser_chk #(
  parameter int PHV_W   = 256,
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_ready,
  input logic               phv_valid,
  input logic               parse_error,
  input logic [PHV_W-1:0]   phv_data,
  input logic [ENTRIES-1:0] ent_en
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phv_valid |=> !phv_valid);

  // R8
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parse_error |=> !parse_error);

  // R8
  err_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parse_error |-> (phv_data == '0));

  // R7
  excl_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(phv_valid && parse_error));

  // R2
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phv_valid || parse_error) |-> in_ready);

  // R11
  tbl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(ent_en));
endmodule

bind tcam_parser tcam_parser_chk #(.PHV_W(PHV_W), .ENTRIES(ENTRIES)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .phv_valid(phv_valid),
  .parse_error(parse_error), .phv_data(phv_data), .ent_en(ent_en)
);

// File: tb/tcam_parser_tb_top.sv
`timescale 1ns/1ps
module tcam_parser_tb_top;
  localparam int ENT  = 16;
  localparam int PHVB = 32;
  localparam int MAXS = 16;
  localparam int INST = 5;

  logic clk = 0, rst_n = 0;
  logic tbl_we = 0, tbl_en = 0;
  logic [3:0] tbl_addr = 0;
  logic [39:0] tbl_val = 0, tbl_care = 0;
  logic [7:0] tbl_next = 0;
  logic [4:0] tbl_adv = 0;
  logic [3:0] tbl_xlen = 0;
  logic [4:0] tbl_xoff = 0;
  logic in_valid = 0, in_last = 0;
  logic [31:0] in_data = 0;
  logic [2:0] in_nbytes = 0;
  logic in_ready, phv_valid, parse_error;
  logic [255:0] phv_data;
  logic [3:0] phv_tag;

  int errors = 0, checks = 0;

  bit          m_en [ENT];
  logic [39:0] m_val [ENT], m_care [ENT];
  logic [7:0]  m_next [ENT];
  int          m_adv [ENT], m_xlen [ENT], m_xoff [ENT];
  logic [7:0]  pk [256];
  int          pk_len;

  always #2.5 clk = ~clk;

  tcam_parser #(.ENTRIES(ENT), .PHV_BYTES(PHVB), .MAX_STEPS(MAXS), .INST_ID(INST)) dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_en(tbl_en),
    .tbl_val(tbl_val), .tbl_care(tbl_care), .tbl_next(tbl_next), .tbl_adv(tbl_adv),
    .tbl_xlen(tbl_xlen), .tbl_xoff(tbl_xoff), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .in_nbytes(in_nbytes), .phv_valid(phv_valid),
    .phv_data(phv_data), .phv_tag(phv_tag), .parse_error(parse_error)
  );

  task automatic chk(string req, logic [255:0] act, logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rd(int i);
    return (i < pk_len && i < 64) ? pk[i] : 8'h00;
  endfunction

  task automatic model(output bit e_err, output logic [255:0] e_phv, output int e_steps);
    int cur; logic [7:0] st; logic [39:0] key; int h;
    cur = 0; st = 0; e_phv = '0; e_err = 0; e_steps = 0;
    for (int s = 0; s < MAXS; s++) begin
      e_steps = s + 1;
      key = {st, rd(cur), rd(cur+1), rd(cur+2), rd(cur+3)};
      h = -1;
      for (int i = ENT - 1; i >= 0; i--)
        if (m_en[i] && (((key ^ m_val[i]) & m_care[i]) == 40'd0)) h = i;
      if (h < 0 || cur + m_adv[h] > pk_len) begin e_err = 1; e_phv = '0; return; end
      for (int t = 0; t < m_xlen[h]; t++)
        if (m_xoff[h] + t < PHVB) e_phv[8*(m_xoff[h]+t) +: 8] = rd(cur + t);
      if (m_next[h] == 8'hFF) return;
      if (s == MAXS - 1) begin e_err = 1; e_phv = '0; return; end
      cur += m_adv[h];
      st = m_next[h];
    end
  endtask

  task automatic wr(int idx, bit en, logic [39:0] v, logic [39:0] c, logic [7:0] nx,
                    int adv, int xl, int xo);
    @(negedge clk);
    tbl_we = 1; tbl_addr = 4'(idx); tbl_en = en; tbl_val = v; tbl_care = c;
    tbl_next = nx; tbl_adv = 5'(adv); tbl_xlen = 4'(xl); tbl_xoff = 5'(xo);
    @(negedge clk);
    tbl_we = 0;
    m_en[idx] = en; m_val[idx] = v; m_care[idx] = c; m_next[idx] = nx;
    m_adv[idx] = (adv > 16) ? 16 : adv; m_xlen[idx] = xl; m_xoff[idx] = xo;
  endtask

  task automatic run(string req, bit inject);
    bit e_err; logic [255:0] e_phv; int e_steps; int nw; int cnt;
    model(e_err, e_phv, e_steps);
    @(negedge clk);
    chk({req, " R2 ready idle"}, in_ready, 1);
    nw = (pk_len + 3) / 4;
    for (int w = 0; w < nw; w++) begin
      in_valid = 1;
      in_data = {rd(4*w), rd(4*w+1), rd(4*w+2), rd(4*w+3)};
      in_last = (w == nw - 1);
      in_nbytes = (w == nw - 1) ? 3'(pk_len - 4*w) : 3'd4;
      @(negedge clk);
    end
    in_valid = 0; in_last = 0;
    if (inject) begin
      tbl_we = 1; tbl_addr = 0; tbl_en = 0; tbl_val = 0; tbl_care = 0;
    end
    cnt = 0;
    do begin
      @(negedge clk);
      tbl_we = 0;
      cnt++;
      if (cnt == 1 && !(phv_valid || parse_error)) chk({req, " R2 ready low"}, in_ready, 0);
    end while (!(phv_valid || parse_error) && cnt < 100);
    chk({req, " R8 error flag"}, parse_error, e_err);
    chk({req, " R7 done flag"}, phv_valid, !e_err);
    chk({req, " R7 latency"}, cnt, e_steps);
    chk({req, " R5 vector"}, phv_data, e_phv);
    chk({req, " R12 tag"}, phv_tag, INST);
    @(negedge clk);
    chk({req, " R7 one cycle"}, phv_valid | parse_error, 0);
  endtask

  task automatic setp(int n, logic [7:0] b [$]);
    pk_len = n;
    for (int i = 0; i < 256; i++) pk[i] = (i < b.size()) ? b[i] : 8'h00;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] q [$];
    void'($urandom(32'd1234));
    for (int i = 0; i < ENT; i++) begin m_en[i] = 0; m_adv[i] = 0; m_xlen[i] = 0; m_xoff[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready", in_ready, 1);
    chk("R1 valid", phv_valid, 0);
    chk("R1 error", parse_error, 0);
    chk("R1 vector", phv_data, 0);
    setp(4, '{8'h08, 8'h00, 8'h11, 8'h22});
    run("R1 empty table", 0);

    wr(0, 1, {8'h00, 32'h0800_0000}, {8'hFF, 32'hFFFF_0000}, 8'h01, 4, 4, 0);
    wr(1, 1, {8'h00, 32'h0800_0000}, {8'hFF, 32'hFF00_0000}, 8'h02, 2, 2, 4);
    wr(2, 1, {8'h01, 32'h0},         {8'hFF, 32'h0},         8'hFF, 4, 4, 8);
    wr(3, 1, {8'h02, 32'h4000_0000}, {8'hFF, 32'hF000_0000}, 8'h03, 3, 3, 12);
    wr(4, 1, {8'h03, 32'hAA00_0000}, {8'hFF, 32'hFF00_0000}, 8'h03, 1, 4, 30);
    wr(5, 1, {8'h03, 32'h0},         {8'hFF, 32'h0},         8'hFF, 0, 0, 0);

    setp(8, '{8'h08, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66});
    run("R4 priority", 0);
    setp(5, '{8'h08, 8'h05, 8'h4A, 8'hBB, 8'hCC});
    run("R3 care zero-fill", 0);
    setp(3, '{8'h08, 8'h00, 8'h01});
    run("R9 overrun", 0);
    q = '{8'h08, 8'h01, 8'h40, 8'h00, 8'h00};
    for (int i = 0; i < 20; i++) q.push_back(8'hAA);
    setp(25, q);
    run("R10 step limit", 0);
    setp(8, '{8'h08, 8'h01, 8'h40, 8'h00, 8'h00, 8'hAA, 8'hAA, 8'hBB});
    run("R5 vector edge", 0);
    setp(8, '{8'h08, 8'h00, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66});
    run("R11 write busy", 1);
    run("R11 after busy", 0);
    wr(2, 1, {8'h01, 32'h0}, {8'hFF, 32'h0}, 8'hFF, 20, 4, 9);
    q = '{};
    for (int i = 0; i < 20; i++) q.push_back(8'(i * 7 + 1));
    q[0] = 8'h08; q[1] = 8'h00;
    setp(20, q);
    run("R6 clamp R11 idle write", 0);
    wr(2, 1, {8'h01, 32'h0}, {8'hFF, 32'h0}, 8'hFF, 4, 4, 8);

    for (int n = 0; n < 150; n++) begin
      int len;
      q = '{};
      len = 1 + int'($urandom % 24);
      for (int i = 0; i < len; i++) begin
        case ($urandom % 8)
          0: q.push_back(8'h08);
          1: q.push_back(8'h00);
          2: q.push_back(8'h40 | 8'($urandom % 16));
          3, 4: q.push_back(8'hAA);
          default: q.push_back(8'($urandom));
        endcase
      end
      if ($urandom % 2 == 1) q[0] = 8'h08;
      setp(len, q);
      run("R6 random walk", 0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule